// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block turns the descriptor table of one storage command into a stream of data segments for a DMA data mover. A command is launched with a table base address and an entry count. The walker reads each 16-byte entry one 32-bit word at a time over a request/response memory port. It decodes the segment address, the length and the flags of each entry, and presents every data segment on a valid/ready output as an address, a byte length and a snoop attribute.

An entry whose extension flag is set is not a data block. It points to a further table of entries, and the walk continues there. Tables that break the format or the limits stop the walk. The walker then gives a one-cycle error pulse with a reason code. A command that ends cleanly gives a one-cycle done pulse after its last segment is accepted.

Top module: `sgl_walker`

## Requirements
- R1: A start with an entry count above MAX_ENTRIES (default 16) issues no memory read and emits no segment, and ends with an error pulse carrying code 1. A start with a count of zero gives a done pulse with no read and no segment.
- R2: Each entry occupies 16 bytes. Its four words are read at entry base +0, +4, +8 and +12, in that order, with at most one read outstanding at a time. Words 1 and 2 are fetched and have no effect on the output.
- R3: Word 0 holds the 32-bit segment address. If bits 1:0 of that address are nonzero, the walk ends with error code 2 and the entry is not emitted.
- R4: Bits 21:0 of word 3 form the count field. If its bits 1:0 are nonzero, the walk ends with error code 3. This check takes priority over the address check of R3.
- R5: The emitted byte length is the count field plus 4. A count field of zero means 4 MB (0x400000 bytes).
- R6: Bit 22 of word 3 is the snoop flag, and it is presented on seg_snoop together with that segment.
- R7: When bit 31 of word 3 is set, the entry is not emitted. The walk continues at the entry's address with (byte length / 16) entries, and any remaining entries of the current table are dropped. An extension that holds zero entries ends the walk with error code 5.
- R8: The entries fetched by a command, counting those in extensions, may not exceed MAX_ENTRIES. An extension that would exceed that number ends the walk with error code 1 before any of its words are read.
- R9: If a segment would take the sum of emitted lengths above TOTAL_LIMIT (default 64 MB), that segment is not emitted and the walk ends with error code 4.
- R10: While seg_valid is high and seg_ready is low, seg_valid, seg_addr, seg_len and seg_snoop hold steady.
- R11: done and err are pulses exactly one cycle long, and they are never high together. err_code is nonzero only while err is high. After done or err, the block issues no reads and emits no segments, whatever responses arrive, until the next start.
- R12: After reset, mem_req_valid, seg_valid, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a walk; sampled while idle |
| tbl_base | input | 32 | Byte address of the first table entry |
| tbl_entries | input | CMD_CNT_W | Number of entries in the first table |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| seg_valid | output | 1 | A segment is offered |
| seg_ready | input | 1 | Data mover takes the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 23 | Segment length in bytes |
| seg_snoop | output | 1 | Segment accesses are snoopable |
| done | output | 1 | One-cycle pulse: walk completed |
| err | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 3 | Reason for the abort, valid with err |

## Verification
A vector table sends single-entry commands through the decoder. It sets apart a plain length, a zero count field that must give the 4 MB maximum, and a top-of-range count field, each with and without the snoop flag. It also covers a misaligned address, a misaligned count, both faults at once (which shows their priority) and an empty extension. Directed walks then use a three-entry table under output backpressure, which separates ordering and hold behaviour from decoding. A chained table shows that an extension redirects the fetch and drops the remaining entries. Over-count requests, over-count extensions and a total above a reduced limit show that each limit stops the walk before anything more is emitted. A stray response after an abort shows that the idle walker stays silent.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    localparam int WORD_BYTES  = 4;
    localparam int ENTRY_WORDS = 4;
    localparam int ENTRY_BYTES = WORD_BYTES * ENTRY_WORDS;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int EXT_BIT     = 31;
    localparam int SNOOP_BIT   = 22;
    localparam int CNT_W       = 22;
    localparam int LEN_W       = CNT_W + 1;
    localparam int EXT_W       = LEN_W - ENTRY_SHIFT;
    localparam logic [LEN_W-1:0] MAX_SEG_BYTES = LEN_W'(1) << CNT_W;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_TOO_MANY   = 3'd1,
        ERR_ADDR_ALIGN = 3'd2,
        ERR_LEN_ALIGN  = 3'd3,
        ERR_OVER_TOTAL = 3'd4,
        ERR_EXT_EMPTY  = 3'd5
    } sgl_err_e;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_DECODE, S_EMIT, S_DONE, S_ERR
    } sgl_state_e;

    // Control bits kept from the fourth word of an entry
    typedef struct packed {
        logic             ext;
        logic             snoop;
        logic [CNT_W-1:0] cnt;
    } sgl_ctl_t;

    typedef struct packed {
        logic [31:0]      addr;
        logic [LEN_W-1:0] len;
        logic             snoop;
        logic             ext;
    } sgl_desc_t;

    // Zero-based count field to byte length; zero selects the maximum
    function automatic logic [LEN_W-1:0] seg_bytes(input logic [CNT_W-1:0] f);
        if (f == '0) return MAX_SEG_BYTES;
        return {1'b0, f} + LEN_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/sgl_decode.sv
module sgl_decode
    import sgl_pkg::*;
(
    input  logic [31:0]      w0,
    input  sgl_ctl_t         ctl,
    output sgl_desc_t        desc,
    output logic [EXT_W-1:0] ext_n,
    output sgl_err_e         fault
);
    always_comb begin
        desc.addr  = w0;
        desc.ext   = ctl.ext;
        desc.snoop = ctl.snoop;
        desc.len   = seg_bytes(ctl.cnt);
        ext_n      = desc.len[LEN_W-1:ENTRY_SHIFT];
        fault      = ERR_NONE;
        if (ctl.cnt[1:0] != 2'b00)
            fault = ERR_LEN_ALIGN;
        else if (w0[1:0] != 2'b00)
            fault = ERR_ADDR_ALIGN;
        else if (ctl.ext && ext_n == '0)
            fault = ERR_EXT_EMPTY;
    end
endmodule

// File: rtl/sgl_limits.sv
module sgl_limits
    import sgl_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    parameter int TOTAL_LIMIT = 64 * 1024 * 1024,
    parameter int USE_W       = 5,
    parameter int TOT_W       = 28
) (
    input  logic [USE_W-1:0] used,
    input  logic [EXT_W-1:0] ext_n,
    input  logic [TOT_W-1:0] total,
    input  logic [LEN_W-1:0] len,
    output logic             entries_over,
    output logic             total_over
);
    localparam int SUM_W = (EXT_W > USE_W ? EXT_W : USE_W) + 1;

    logic [SUM_W-1:0] ent_sum;
    logic [TOT_W-1:0] tot_sum;

    always_comb begin
        ent_sum      = SUM_W'(ext_n) + SUM_W'(used);
        entries_over = ent_sum > SUM_W'(MAX_ENTRIES);
        tot_sum      = total + TOT_W'(len);
        total_over   = tot_sum > TOT_W'(TOTAL_LIMIT);
    end
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
    import sgl_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    parameter int TOTAL_LIMIT = 64 * 1024 * 1024,
    parameter int CMD_CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [31:0]          tbl_base,
    input  logic [CMD_CNT_W-1:0] tbl_entries,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [31:0]          mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [31:0]          mem_rsp_data,
    output logic                 seg_valid,
    input  logic                 seg_ready,
    output logic [31:0]          seg_addr,
    output logic [LEN_W-1:0]     seg_len,
    output logic                 seg_snoop,
    output logic                 done,
    output logic                 err,
    output logic [2:0]           err_code
);
    localparam int USE_W     = $clog2(MAX_ENTRIES + 1);
    localparam int LIM_W     = $clog2(TOTAL_LIMIT);
    localparam int TOT_W     = (LIM_W > LEN_W ? LIM_W : LEN_W) + 2;
    localparam logic [1:0] LAST_WORD = 2'(ENTRY_WORDS - 1);

    sgl_state_e       state;
    logic [31:0]      cur_addr;
    logic [1:0]       word_idx;
    logic [USE_W-1:0] remain_q;
    logic [USE_W-1:0] used_q;
    logic [TOT_W-1:0] total_q;
    logic [31:0]      w0_q;
    sgl_ctl_t         ctl_q;
    logic [31:0]      seg_addr_q;
    logic [LEN_W-1:0] seg_len_q;
    logic             seg_snoop_q;
    sgl_err_e         err_code_q;

    sgl_desc_t        desc_c;
    logic [EXT_W-1:0] ext_n_c;
    sgl_err_e         fault_c;
    logic             entries_over;
    logic             total_over;

    sgl_decode u_decode (
        .w0    (w0_q),
        .ctl   (ctl_q),
        .desc  (desc_c),
        .ext_n (ext_n_c),
        .fault (fault_c)
    );

    sgl_limits #(
        .MAX_ENTRIES (MAX_ENTRIES),
        .TOTAL_LIMIT (TOTAL_LIMIT),
        .USE_W       (USE_W),
        .TOT_W       (TOT_W)
    ) u_limits (
        .used         (used_q),
        .ext_n        (ext_n_c),
        .total        (total_q),
        .len          (desc_c.len),
        .entries_over (entries_over),
        .total_over   (total_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cur_addr    <= '0;
            word_idx    <= '0;
            remain_q    <= '0;
            used_q      <= '0;
            total_q     <= '0;
            w0_q        <= '0;
            ctl_q       <= '0;
            seg_addr_q  <= '0;
            seg_len_q   <= '0;
            seg_snoop_q <= 1'b0;
            err_code_q  <= ERR_NONE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    cur_addr <= tbl_base;
                    word_idx <= '0;
                    total_q  <= '0;
                    if (tbl_entries > CMD_CNT_W'(MAX_ENTRIES)) begin
                        err_code_q <= ERR_TOO_MANY;
                        state      <= S_ERR;
                    end else if (tbl_entries == '0) begin
                        state <= S_DONE;
                    end else begin
                        remain_q <= USE_W'(tbl_entries);
                        used_q   <= USE_W'(tbl_entries);
                        state    <= S_REQ;
                    end
                end
                S_REQ: if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    if (word_idx == 2'd0) w0_q <= mem_rsp_data;
                    if (word_idx == LAST_WORD) begin
                        ctl_q <= '{ext:   mem_rsp_data[EXT_BIT],
                                   snoop: mem_rsp_data[SNOOP_BIT],
                                   cnt:   mem_rsp_data[CNT_W-1:0]};
                        state <= S_DECODE;
                    end else begin
                        word_idx <= word_idx + 2'd1;
                        state    <= S_REQ;
                    end
                end
                S_DECODE: begin
                    if (fault_c != ERR_NONE) begin
                        err_code_q <= fault_c;
                        state      <= S_ERR;
                    end else if (desc_c.ext) begin
                        if (entries_over) begin
                            err_code_q <= ERR_TOO_MANY;
                            state      <= S_ERR;
                        end else begin
                            cur_addr <= desc_c.addr;
                            remain_q <= USE_W'(ext_n_c);
                            used_q   <= used_q + USE_W'(ext_n_c);
                            word_idx <= '0;
                            state    <= S_REQ;
                        end
                    end else if (total_over) begin
                        err_code_q <= ERR_OVER_TOTAL;
                        state      <= S_ERR;
                    end else begin
                        seg_addr_q  <= desc_c.addr;
                        seg_len_q   <= desc_c.len;
                        seg_snoop_q <= desc_c.snoop;
                        state       <= S_EMIT;
                    end
                end
                S_EMIT: if (seg_ready) begin
                    total_q <= total_q + TOT_W'(seg_len_q);
                    if (remain_q == USE_W'(1)) begin
                        state <= S_DONE;
                    end else begin
                        remain_q <= remain_q - USE_W'(1);
                        cur_addr <= cur_addr + 32'(ENTRY_BYTES);
                        word_idx <= '0;
                        state    <= S_REQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state == S_REQ);
    assign mem_req_addr  = cur_addr + 32'({word_idx, 2'b00});
    assign seg_valid     = (state == S_EMIT);
    assign seg_addr      = seg_addr_q;
    assign seg_len       = seg_len_q;
    assign seg_snoop     = seg_snoop_q;
    assign done          = (state == S_DONE);
    assign err           = (state == S_ERR);
    assign err_code      = err ? err_code_q : 3'd0;
endmodule

// File: rtl/sgl_walker_chk.sv
module sgl_walker_chk
    import sgl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [1:0]       req_addr_lo,
    input logic             mem_rsp_valid,
    input logic             seg_valid,
    input logic             seg_ready,
    input logic [31:0]      seg_addr,
    input logic [LEN_W-1:0] seg_len,
    input logic             seg_snoop,
    input logic             done,
    input logic             err,
    input logic [2:0]       err_code
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            outstanding <= 1'b1;
        else if (mem_rsp_valid)
            outstanding <= 1'b0;
    end

    assert_one_read_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !outstanding);

    assert_req_word_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> req_addr_lo == 2'b00);

    assert_seg_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> seg_addr[1:0] == 2'b00);

    assert_seg_len_R5: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_len != '0 && seg_len <= MAX_SEG_BYTES && seg_len[1:0] == 2'b00));

    assert_seg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_snoop)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_code_with_err_R11: assert property (@(posedge clk) disable iff (rst)
        (err_code != 3'd0) == err);
endmodule

bind sgl_walker sgl_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .req_addr_lo   (mem_req_addr[1:0]),
    .mem_rsp_valid (mem_rsp_valid),
    .seg_valid     (seg_valid),
    .seg_ready     (seg_ready),
    .seg_addr      (seg_addr),
    .seg_len       (seg_len),
    .seg_snoop     (seg_snoop),
    .done          (done),
    .err           (err),
    .err_code      (err_code)
);

// File: tb/sgl_walker_bench.sv
`timescale 1ns/1ps
module sgl_walker_bench;
    localparam int LIMIT = 8 * 1024 * 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [7:0]  tbl_entries = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        model_v = 1'b0, spur = 1'b0;
    logic        mem_rsp_valid;
    logic [31:0] model_d = '0, spur_d = '0, mem_rsp_data;
    logic        seg_valid, seg_ready, seg_snoop;
    logic [31:0] seg_addr;
    logic [22:0] seg_len;
    logic        done, err;
    logic [2:0]  err_code;
    logic        stall_en = 1'b0;
    logic [7:0]  cyc = '0;

    logic [31:0] mem [256];

    int n_chk = 0, n_fail = 0;
    int cap_n, done_n, err_n, req_n, stall_viol, pulse_long, last_code;
    logic [31:0] cap_addr [8];
    logic [31:0] cap_len  [8];
    logic        cap_snp  [8];
    logic [31:0] req_a    [16];
    logic        hold_pend = 1'b0, done_prev = 1'b0, err_prev = 1'b0;
    logic [31:0] h_addr;
    logic [22:0] h_len;
    logic        h_snp;

    always #2 clk = ~clk;

    sgl_walker #(.TOTAL_LIMIT(LIMIT)) u_sgl_walker (
        .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base), .tbl_entries(tbl_entries),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_snoop(seg_snoop), .done(done), .err(err), .err_code(err_code)
    );

    assign mem_req_ready = (cyc[1:0] != 2'b01);
    assign seg_ready     = stall_en ? cyc[0] : 1'b1;
    assign mem_rsp_valid = model_v | spur;
    assign mem_rsp_data  = spur ? spur_d : model_d;

    always @(posedge clk) begin
        cyc     <= cyc + 8'd1;
        model_v <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            model_v <= 1'b1;
            model_d <= mem[mem_req_addr[9:2]];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend && (!seg_valid || seg_addr != h_addr || seg_len != h_len || seg_snoop != h_snp))
                stall_viol++;
            hold_pend = seg_valid && !seg_ready;
            h_addr = seg_addr; h_len = seg_len; h_snp = seg_snoop;
            if (seg_valid && seg_ready) begin
                if (cap_n < 8) begin
                    cap_addr[cap_n] = seg_addr;
                    cap_len[cap_n]  = 32'(seg_len);
                    cap_snp[cap_n]  = seg_snoop;
                end
                cap_n++;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (req_n < 16) req_a[req_n] = mem_req_addr;
                req_n++;
            end
            if (done) begin done_n++; if (done_prev) pulse_long++; end
            if (err) begin err_n++; last_code = int'(err_code); if (err_prev) pulse_long++; end
            done_prev = done;
            err_prev  = err;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic put_entry(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w3);
        mem[a[9:2]]        = w0;
        mem[a[9:2] + 8'd1] = 32'hDEAD_BEEF;
        mem[a[9:2] + 8'd2] = 32'hFFFF_FFFF;
        mem[a[9:2] + 8'd3] = w3;
    endtask

    task automatic run_cmd(input logic [31:0] base, input int cnt);
        cap_n = 0; done_n = 0; err_n = 0; req_n = 0;
        stall_viol = 0; pulse_long = 0; last_code = 0;
        @(negedge clk);
        tbl_base = base; tbl_entries = 8'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000 && done_n == 0 && err_n == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Single-entry vectors: word 0, word 3, expected code, length, snoop
    localparam int NV = 8;
    localparam logic [31:0] V_W0 [NV] = '{32'h1000_0000, 32'h2000_0004, 32'h3000_0000, 32'h4000_0002,
                                          32'h5000_0000, 32'h6000_0008, 32'h7000_0000, 32'h7000_0001};
    localparam logic [31:0] V_W3 [NV] = '{32'h0000_0FFC, 32'h0040_0000, 32'h003F_FFFC, 32'h0000_0010,
                                          32'h0000_0011, 32'h0040_0004, 32'h8000_0008, 32'h0000_0012};
    localparam int          V_ERR [NV] = '{0, 0, 0, 2, 3, 0, 5, 3};
    localparam logic [31:0] V_LEN [NV] = '{32'h1000, 32'h40_0000, 32'h40_0000, 0, 0, 32'h8, 0, 0};
    localparam logic        V_SNP [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R12 reset mem_req_valid", 64'(mem_req_valid), 0);
        chk_eq("R12 reset seg_valid", 64'(seg_valid), 0);
        chk_eq("R12 reset done/err", 64'({done, err}), 0);

        for (int v = 0; v < NV; v++) begin
            put_entry(32'h0, V_W0[v], V_W3[v]);
            run_cmd(32'h0, 1);
            chk_eq($sformatf("R3/R4/R7 vec%0d code", v), 64'(last_code), 64'(V_ERR[v]));
            chk_eq($sformatf("R2 vec%0d reads", v), 64'(req_n), 4);
            chk_eq($sformatf("R2 vec%0d word3 addr", v), 64'(req_a[3]), 64'hC);
            if (V_ERR[v] == 0) begin
                chk_eq($sformatf("R5 vec%0d segs", v), 64'(cap_n), 1);
                chk_eq($sformatf("R5 vec%0d len", v), 64'(cap_len[0]), 64'(V_LEN[v]));
                chk_eq($sformatf("R6 vec%0d snoop", v), 64'(cap_snp[0]), 64'(V_SNP[v]));
                chk_eq($sformatf("R3 vec%0d addr", v), 64'(cap_addr[0]), 64'(V_W0[v]));
                chk_eq($sformatf("R11 vec%0d done", v), 64'(done_n), 1);
            end else begin
                chk_eq($sformatf("R3 vec%0d no seg", v), 64'(cap_n), 0);
                chk_eq($sformatf("R11 vec%0d err", v), 64'(err_n), 1);
            end
            chk_eq($sformatf("R11 vec%0d pulse width", v), 64'(pulse_long), 0);
        end

        // Three entries under backpressure
        put_entry(32'h100, 32'h0001_0000, 32'h0000_00FC);
        put_entry(32'h110, 32'h0002_0040, 32'h0040_003C);
        put_entry(32'h120, 32'h0003_0000, 32'h0000_0004);
        stall_en = 1'b1;
        run_cmd(32'h100, 3);
        stall_en = 1'b0;
        chk_eq("R2 three-entry segs", 64'(cap_n), 3);
        chk_eq("R2 order addr0", 64'(cap_addr[0]), 64'h0001_0000);
        chk_eq("R2 order addr1", 64'(cap_addr[1]), 64'h0002_0040);
        chk_eq("R2 order addr2", 64'(cap_addr[2]), 64'h0003_0000);
        chk_eq("R5 len1", 64'(cap_len[1]), 64'h40);
        chk_eq("R6 snoop1", 64'(cap_snp[1]), 1);
        chk_eq("R2 second entry base", 64'(req_a[4]), 64'h110);
        chk_eq("R10 hold under stall", 64'(stall_viol), 0);
        chk_eq("R11 three-entry done", 64'(done_n), 1);

        // Extension chain
        put_entry(32'h200, 32'h0A00_0000, 32'h0000_001C);
        put_entry(32'h210, 32'h0000_0300, 32'h8000_001C);
        put_entry(32'h220, 32'h0E00_0000, 32'h0000_0004);
        put_entry(32'h300, 32'h0B00_0000, 32'h0040_0000);
        put_entry(32'h310, 32'h0C00_0010, 32'h0000_0FFC);
        run_cmd(32'h200, 3);
        chk_eq("R7 chain segs", 64'(cap_n), 3);
        chk_eq("R7 chain seg1 addr", 64'(cap_addr[1]), 64'h0B00_0000);
        chk_eq("R7 chain seg2 addr", 64'(cap_addr[2]), 64'h0C00_0010);
        chk_eq("R7 chain fetch base", 64'(req_a[8]), 64'h300);
        chk_eq("R7 chain done", 64'(done_n), 1);

        // Count above limit
        run_cmd(32'h100, 17);
        chk_eq("R1 too many code", 64'(last_code), 1);
        chk_eq("R1 too many reads", 64'(req_n), 0);
        chk_eq("R1 too many segs", 64'(cap_n), 0);

        // Count of zero
        run_cmd(32'h100, 0);
        chk_eq("R1 zero done", 64'(done_n), 1);
        chk_eq("R1 zero reads", 64'(req_n), 0);

        // Extension pushing entry count past the limit
        put_entry(32'h380, 32'h0000_0000, 32'h8000_00FC);
        run_cmd(32'h380, 1);
        chk_eq("R8 ext over code", 64'(last_code), 1);
        chk_eq("R8 ext over reads", 64'(req_n), 4);
        chk_eq("R8 ext over segs", 64'(cap_n), 0);

        // Running total above the reduced limit
        put_entry(32'h3C0, 32'h0D00_0000, 32'h0000_0000);
        put_entry(32'h3D0, 32'h0E00_0000, 32'h0000_0000);
        put_entry(32'h3E0, 32'h0F00_0000, 32'h0000_0004);
        run_cmd(32'h3C0, 3);
        chk_eq("R9 total code", 64'(last_code), 4);
        chk_eq("R9 total segs", 64'(cap_n), 2);

        // Stray response while idle
        cap_n = 0; done_n = 0; err_n = 0; req_n = 0;
        @(negedge clk);
        spur = 1'b1; spur_d = 32'h1234_5678;
        @(negedge clk);
        spur = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R11 idle ignores response", 64'({28'(cap_n), 12'(done_n), 12'(err_n), 12'(req_n)}), 0);

        put_entry(32'h0, V_W0[0], V_W3[0]);
        run_cmd(32'h0, 1);
        chk_eq("R11 restart after error", 64'(cap_len[0]), 64'h1000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule